// File: doc/BRIEF.md
# ECG R-Peak and Beat-Interval Detector

This block watches a single ECG lead, delivered as signed 10-bit samples at 256 samples per second with one valid strobe per sample, and finds heartbeats with a slope-energy detector. Each sample passes through a band-pass stage, which is a boxcar low-pass followed by a lagged-difference high-pass. It then goes through a first difference and a squaring stage, and the squared slope is compared against a threshold that adapts to the height of recent beats. No integration window follows the squarer: detection works on the squared slope directly.

A run of samples whose squared slope exceeds the threshold forms a QRS episode. The sample with the largest squared slope inside the episode is taken as the R peak. When the episode closes, the block reports the distance from the previous R peak as a fixed-point value in seconds. Because one sample lasts 1/256 s, the raw sample count read with 8 fractional bits is already that value. A refractory length, given on an input port, stops a new episode from starting too soon after a peak. This removes the echoes that the filter chain leaves behind each beat.

Top module: `ecg_rr_detector`

## Requirements
- R1: A sample is consumed only on a clock edge where `smp_valid` is 1, and `smp_data` is ignored on every other edge. `rr_valid` is a single-cycle pulse, and it is only ever high in the cycle after an edge that consumed a sample.
- R2: With x[n] the signed input, the filter chain is lp[n] = x[n]+x[n-1]+x[n-2]+x[n-3], hp[n] = lp[n]-lp[n-8], d[n] = hp[n]-hp[n-1], and s[n] = d[n]². Samples before reset count as zero. The chain treats positive and negative spikes alike.
- R3: A QRS episode starts at a sample where s[n] > threshold and the refractory rule allows it. The episode ends at the first later sample with s[n] ≤ threshold. The R peak is the earliest sample holding the largest s[n] in the episode.
- R4: When an episode ends, `rr_sec` carries the number of samples from the previous R peak to the new one, as unsigned fixed point with 8 fractional bits (count/256 s). `rr_valid` is high in the cycle after the edge that consumed the sample ending the episode.
- R5: The first episode after reset produces no output pulse. It only records its R peak.
- R6: No episode may start at a sample whose distance from the last R peak is `refr_len` or less. A distance of `refr_len`+1 is allowed. Before the first R peak nothing is blocked.
- R7: The threshold is avg>>2. After reset avg = 4·INIT_THR (INIT_THR defaults to 1000). At each episode end, avg becomes avg − (avg>>3) + (P>>3), where P is the episode's peak s value. A spike whose s stays at or below the threshold is not detected.
- R8: While reset is held and in the first cycle after it, `rr_valid` and `rr_sec` are 0, and all filter history is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Sample strobe; one pulse per ECG sample |
| smp_data | input | 10 | Signed ECG sample |
| refr_len | input | 8 | Refractory length in samples |
| rr_valid | output | 1 | Pulse marking a new beat interval |
| rr_sec | output | 16 | Beat interval in seconds, 8 fractional bits |

## Verification
The detector decides combinationally on the sample being consumed, and registers only its output. Each interval is therefore due in the single cycle after the valid edge that carried the episode's closing sample. That sample is the one after the peak for an isolated one-sample spike, and two after the spike's start for a rising two-sample spike. The bench tags each consumed sample with its index and reads `rr_valid` at the next falling edge, so every pulse is matched against the sample that caused it. The same check catches a missing pulse, a pulse one sample early or late, and a pulse in a cycle that consumed no sample. Idle cycles carry junk data so that consuming them by mistake would produce extra beats.

// File: rtl/ecg_rr_pkg.sv
package ecg_rr_pkg;
   // Fractional bits of the interval output: one sample = 1/256 s.
   localparam int FRAC_BITS = 8;

   typedef enum logic {
      QRS_IDLE   = 1'b0,
      QRS_ACTIVE = 1'b1
   } qrs_state_e;
endpackage

// File: rtl/ecg_bandpass.sv
module ecg_bandpass #(
   parameter int X_W    = 10,
   parameter int LP_LEN = 4,
   parameter int HP_LAG = 8,
   parameter int LP_W   = 12,
   parameter int HP_W   = 13
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   en,
   input  logic signed [X_W-1:0]  x_in,
   output logic signed [HP_W-1:0] hp_now
);
   logic signed [LP_W-1:0] lp_now;

   generate
      if (LP_LEN == 1) begin : g_lp_thru
         assign lp_now = LP_W'(x_in);
      end else begin : g_lp_box
         logic signed [X_W-1:0]  xd [LP_LEN-1];
         logic signed [LP_W-1:0] acc;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               for (int i = 0; i < LP_LEN-1; i++) xd[i] <= '0;
            end else if (en) begin
               xd[0] <= x_in;
               for (int i = 1; i < LP_LEN-1; i++) xd[i] <= xd[i-1];
            end
         end

         always_comb begin
            acc = LP_W'(x_in);
            for (int i = 0; i < LP_LEN-1; i++) acc = acc + LP_W'(xd[i]);
         end
         assign lp_now = acc;
      end
   endgenerate

   // Lagged difference removes baseline wander.
   logic signed [LP_W-1:0] lpd [HP_LAG];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < HP_LAG; i++) lpd[i] <= '0;
      end else if (en) begin
         lpd[0] <= lp_now;
         for (int i = 1; i < HP_LAG; i++) lpd[i] <= lpd[i-1];
      end
   end

   assign hp_now = HP_W'(lp_now) - HP_W'(lpd[HP_LAG-1]);
endmodule

// File: rtl/ecg_slope_energy.sv
module ecg_slope_energy #(
   parameter int HP_W = 13,
   parameter int D_W  = 14,
   parameter int SQ_W = 28
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   en,
   input  logic signed [HP_W-1:0] hp_now,
   output logic        [SQ_W-1:0] sq_now
);
   logic signed [HP_W-1:0] hp_prev;
   logic signed [D_W-1:0]  d_now;
   logic signed [SQ_W-1:0] prod;

   always_ff @(posedge clk) begin
      if (!rst_n)  hp_prev <= '0;
      else if (en) hp_prev <= hp_now;
   end

   assign d_now  = D_W'(hp_now) - D_W'(hp_prev);
   assign prod   = SQ_W'(d_now) * SQ_W'(d_now);
   assign sq_now = prod;
endmodule

// File: rtl/ecg_beat_picker.sv
module ecg_beat_picker
   import ecg_rr_pkg::*;
#(
   parameter int SQ_W     = 28,
   parameter int REFR_W   = 8,
   parameter int RR_W     = 16,
   parameter int INIT_THR = 1000,
   parameter int AVG_SH   = 3,
   parameter int THR_SH   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic [SQ_W-1:0]   sq_now,
   input  logic [REFR_W-1:0] refr_len,
   output logic              rr_valid,
   output logic [RR_W-1:0]   rr_sec,
   output logic              in_qrs,
   output logic              have_peak,
   output logic [SQ_W-1:0]   thr
);
   localparam int              AVG_W    = SQ_W + THR_SH + 1;
   localparam logic [RR_W-1:0] RR_MAX   = {RR_W{1'b1}};
   localparam logic [AVG_W-1:0] AVG_INIT = AVG_W'(INIT_THR) << THR_SH;

   qrs_state_e       state_q;
   logic [RR_W-1:0]  cnt_q, cnt_now, pk_off_q;
   logic [SQ_W-1:0]  best_q;
   logic [AVG_W-1:0] avg_q, avg_nx;
   logic             have_peak_q, armed, above, qrs_start, qrs_end, qrs_grow;

   // Samples since the last R peak, saturating.
   assign cnt_now   = (cnt_q == RR_MAX) ? cnt_q : cnt_q + 1'b1;
   assign thr       = SQ_W'(avg_q >> THR_SH);
   assign above     = sq_now > thr;
   assign armed     = !have_peak_q || (cnt_now > RR_W'(refr_len));
   assign qrs_start = en && (state_q == QRS_IDLE) && above && armed;
   assign qrs_end   = en && (state_q == QRS_ACTIVE) && !above;
   assign qrs_grow  = en && (state_q == QRS_ACTIVE) && above && (sq_now > best_q);
   assign avg_nx    = avg_q - (avg_q >> AVG_SH) + AVG_W'(best_q >> AVG_SH);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q     <= QRS_IDLE;
         cnt_q       <= '0;
         pk_off_q    <= '0;
         best_q      <= '0;
         avg_q       <= AVG_INIT;
         have_peak_q <= 1'b0;
         rr_valid    <= 1'b0;
         rr_sec      <= '0;
      end else begin
         rr_valid <= 1'b0;
         if (en) cnt_q <= cnt_now;
         if (qrs_start || qrs_grow) begin
            state_q  <= QRS_ACTIVE;
            best_q   <= sq_now;
            pk_off_q <= cnt_now;
         end
         if (qrs_end) begin
            state_q     <= QRS_IDLE;
            cnt_q       <= cnt_now - pk_off_q;
            avg_q       <= avg_nx;
            have_peak_q <= 1'b1;
            rr_valid    <= have_peak_q;
            if (have_peak_q) rr_sec <= pk_off_q;
         end
      end
   end

   assign in_qrs    = (state_q == QRS_ACTIVE);
   assign have_peak = have_peak_q;
endmodule

// File: rtl/ecg_rr_detector.sv
module ecg_rr_detector
   import ecg_rr_pkg::*;
#(
   parameter int X_W      = 10,
   parameter int LP_LEN   = 4,
   parameter int HP_LAG   = 8,
   parameter int REFR_W   = 8,
   parameter int RR_W     = 16,
   parameter int INIT_THR = 1000,
   parameter int AVG_SH   = 3,
   parameter int THR_SH   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              smp_valid,
   input  logic [X_W-1:0]    smp_data,
   input  logic [REFR_W-1:0] refr_len,
   output logic              rr_valid,
   output logic [RR_W-1:0]   rr_sec
);
   localparam int LP_W = X_W + $clog2(LP_LEN);
   localparam int HP_W = LP_W + 1;
   localparam int D_W  = HP_W + 1;
   localparam int SQ_W = 2 * D_W;

   generate
      if (LP_LEN < 1)          begin : g_bad_lp   $error("LP_LEN must be at least 1");        end
      if (HP_LAG < 1)          begin : g_bad_lag  $error("HP_LAG must be at least 1");        end
      if (RR_W < REFR_W)       begin : g_bad_rr   $error("RR_W must cover REFR_W");           end
      if (RR_W <= FRAC_BITS)   begin : g_bad_frac $error("RR_W must exceed fraction bits");   end
      if (AVG_SH < 1)          begin : g_bad_avg  $error("AVG_SH must be at least 1");        end
   endgenerate

   logic signed [HP_W-1:0] hp_now;
   logic        [SQ_W-1:0] sq_now;
   logic                   in_qrs, have_peak;
   logic        [SQ_W-1:0] thr;

   ecg_bandpass #(
      .X_W(X_W), .LP_LEN(LP_LEN), .HP_LAG(HP_LAG), .LP_W(LP_W), .HP_W(HP_W)
   ) bp_i (
      .clk(clk), .rst_n(rst_n), .en(smp_valid),
      .x_in(signed'(smp_data)), .hp_now(hp_now)
   );

   ecg_slope_energy #(
      .HP_W(HP_W), .D_W(D_W), .SQ_W(SQ_W)
   ) se_i (
      .clk(clk), .rst_n(rst_n), .en(smp_valid),
      .hp_now(hp_now), .sq_now(sq_now)
   );

   ecg_beat_picker #(
      .SQ_W(SQ_W), .REFR_W(REFR_W), .RR_W(RR_W),
      .INIT_THR(INIT_THR), .AVG_SH(AVG_SH), .THR_SH(THR_SH)
   ) bk_i (
      .clk(clk), .rst_n(rst_n), .en(smp_valid), .sq_now(sq_now),
      .refr_len(refr_len), .rr_valid(rr_valid), .rr_sec(rr_sec),
      .in_qrs(in_qrs), .have_peak(have_peak), .thr(thr)
   );
endmodule

// File: rtl/ecg_rr_chk.sv
module ecg_rr_chk #(
   parameter int REFR_W = 8,
   parameter int RR_W   = 16,
   parameter int SQ_W   = 28
) (
   input logic              clk,
   input logic              rst_n,
   input logic              smp_valid,
   input logic [REFR_W-1:0] refr_len,
   input logic              rr_valid,
   input logic [RR_W-1:0]   rr_sec,
   input logic              in_qrs,
   input logic              have_peak,
   input logic [SQ_W-1:0]   thr
);
   assert_pulse_after_sample_R1: assert property (@(posedge clk) disable iff (!rst_n)
      rr_valid |-> $past(smp_valid));

   assert_pulse_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
      rr_valid |=> !rr_valid);

   assert_qrs_hold_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(smp_valid) |-> $stable(in_qrs));

   assert_rr_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rr_valid |-> (rr_sec != '0));

   assert_first_beat_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rr_valid |-> $past(have_peak));

   assert_rr_beyond_refr_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rr_valid |-> (rr_sec > RR_W'($past(refr_len))));

   assert_thr_moves_at_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(thr) |-> ($past(in_qrs) && !in_qrs));
endmodule

bind ecg_rr_detector ecg_rr_chk #(
   .REFR_W(REFR_W), .RR_W(RR_W), .SQ_W(SQ_W)
) chk_i (
   .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .refr_len(refr_len),
   .rr_valid(rr_valid), .rr_sec(rr_sec), .in_qrs(in_qrs),
   .have_peak(have_peak), .thr(thr)
);

// File: tb/ecg_rr_detector_tb_top.sv
module ecg_rr_detector_tb_top;
   localparam int X_W    = 10;
   localparam int REFR_W = 8;
   localparam int RR_W   = 16;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              smp_valid = 1'b0;
   logic [X_W-1:0]    smp_data = '0;
   logic [REFR_W-1:0] refr_len = 8'd51;
   logic              rr_valid;
   logic [RR_W-1:0]   rr_sec;

   int    checks = 0;
   int    errors = 0;
   bit    done = 1'b0;
   int    stim [0:1023];
   int    n_samp = 0;
   int    exp_idx [0:7];
   int    exp_val [0:7];
   string exp_tag [0:7];
   int    n_exp = 0;

   always #2.5 clk = ~clk;

   ecg_rr_detector dut_i (
      .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
      .refr_len(refr_len), .rr_valid(rr_valid), .rr_sec(rr_sec)
   );

   task automatic new_scen(input int n);
      for (int i = 0; i < 1024; i++) stim[i] = 0;
      n_samp = n;
      n_exp  = 0;
   endtask

   task automatic add_exp(input int idx, input int val, input string tag);
      exp_idx[n_exp] = idx;
      exp_val[n_exp] = val;
      exp_tag[n_exp] = tag;
      n_exp++;
   endtask

   task automatic do_reset(input logic [REFR_W-1:0] refr);
      rst_n     = 1'b0;
      smp_valid = 1'b0;
      smp_data  = '0;
      refr_len  = refr;
      repeat (3) @(negedge clk);
      checks++;
      if (rr_valid !== 1'b0 || rr_sec !== '0) begin
         errors++;
         $display("FAIL R8 in reset: rr_valid=%0b rr_sec=%0d expected 0 and 0", rr_valid, rr_sec);
      end
      rst_n = 1'b1;
      @(negedge clk);
      checks++;
      if (rr_valid !== 1'b0 || rr_sec !== '0) begin
         errors++;
         $display("FAIL R8 after reset: rr_valid=%0b rr_sec=%0d expected 0 and 0", rr_valid, rr_sec);
      end
   endtask

   // Drive the scenario; every gap_mod-th cycle idle (0 = no gaps).
   task automatic run_scen(input int gap_mod, input string name);
      int k = 0;
      int prev = -1;
      int e = 0;
      int spur = 0;
      int cyc = 0;
      while (k < n_samp || prev != -1) begin
         @(negedge clk);
         if (rr_valid) begin
            if (prev < 0) begin
               spur++;
               $display("FAIL R1 %s: pulse after idle cycle, rr_sec=%0d expected no pulse", name, rr_sec);
            end else if (e < n_exp && exp_idx[e] == prev) begin
               checks++;
               if (rr_sec !== RR_W'(exp_val[e])) begin
                  errors++;
                  $display("FAIL %s: rr_sec=%0d expected %0d", exp_tag[e], rr_sec, exp_val[e]);
               end
               e++;
            end else begin
               spur++;
               $display("FAIL R3 R5 %s: stray pulse at sample %0d rr_sec=%0d expected none", name, prev, rr_sec);
            end
         end else if (prev >= 0 && e < n_exp && exp_idx[e] == prev) begin
            checks++;
            errors++;
            $display("FAIL %s: no pulse at sample %0d, expected rr_sec=%0d", exp_tag[e], prev, exp_val[e]);
            e++;
         end
         if (k < n_samp && !(gap_mod > 0 && (cyc % gap_mod) == gap_mod - 1)) begin
            smp_valid = 1'b1;
            smp_data  = X_W'(stim[k]);
            prev      = k;
            k++;
         end else begin
            smp_valid = 1'b0;
            smp_data  = 10'h1FF; // junk that must be ignored (R1)
            prev      = -1;
         end
         cyc++;
      end
      smp_valid = 1'b0;
      checks++;
      if (e != n_exp || spur != 0) begin
         errors++;
         $display("FAIL R1 R5 %s: matched=%0d stray=%0d expected %0d and 0", name, e, spur, n_exp);
      end
   endtask

   initial begin
      // Scenario 1: refractory 51, idle cycles with junk data.
      // Peaks 20 (first, silent R5), small 40 at 120 (s=1600 <= thr 2125, R7),
      // 300, rising pair at 500/501 (peak 501), refractory spike at 540, 700.
      do_reset(8'd51);
      new_scen(800);
      stim[20] = 200; stim[120] = 40; stim[300] = 200;
      stim[500] = 100; stim[501] = 200; stim[540] = 200; stim[700] = 200;
      add_exp(301, 280, "R4 R7 interval 1.09375 s past a sub-threshold spike");
      add_exp(502, 201, "R3 peak on the larger second sample");
      add_exp(701, 199, "R6 spike 39 samples after a peak ignored");
      run_scen(3, "scenario1");

      // Scenario 2: refractory 20, no gaps. Spike at 31 is 21 after 10;
      // spike at 51 sits exactly 20 after 31 (blocked), its filter echo at 55 (R2) is taken.
      do_reset(8'd20);
      new_scen(500);
      stim[10] = 200; stim[31] = 200; stim[51] = 200;
      stim[200] = -200; stim[400] = -200;
      add_exp(32, 21, "R6 start one sample past the refractory window");
      add_exp(56, 24, "R6 R2 start at window edge blocked, echo at 55 detected");
      add_exp(201, 145, "R2 negative spike detected");
      add_exp(401, 200, "R4 interval between negative spikes");
      run_scen(0, "scenario2");

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule